// File: doc/BRIEF.md
# DMA Span Ownership Tracker

This block sits on the sending side of a message link that has two paths to the receiver: a small mailbox that carries short messages directly, and a shared transfer region in memory for long ones. For each message offered on its input it decides which path to use. When the DMA path is chosen it claims a contiguous span of the region and emits a transfer notice with the span's offset and length. That notice hands the span to the receiver. When acknowledgements come back, the block releases the oldest spans so that they can be used again.

The DMA path is closed after reset. The block first sends an allocation notice when asked to. Only when an allocation acknowledge answers that notice does the DMA path open. The region is a circular buffer kept as a head pointer (next free unit) and a tail pointer (oldest owned-by-receiver unit). A small ring records the end of every outstanding span. Any number of transfers, up to a parameter limit, may be awaiting acknowledgement at once. Acknowledgements are taken in issue order and may be batched, releasing several spans in one cycle.

A span that does not fit before the end of the region is placed at offset zero, and the unused tail is skipped. A long message that cannot be placed anywhere is held with a wait indication. It is never diverted to the mailbox.

Top module: `dmaspan_tracker`

## Requirements
- R1: After reset no mailbox send, transfer notice or allocation notice is asserted, the DMA path is closed, the whole region belongs to the sender, and `msg_ready` is 1.
- R2: `alloc_start` while the DMA path is closed and no notice is pending raises `alloc_notice` for exactly one cycle, in the cycle after. `alloc_ack` with no notice pending is ignored. `alloc_ack` after the notice opens the DMA path. `alloc_start` once the path is open raises no notice.
- R3: While the DMA path is not open, every accepted message goes by mailbox, whatever its length.
- R4: With the path open, a message of more than `MBOX_FRAGS` (default 3) fragments goes by DMA. One of `MBOX_FRAGS` or fewer goes by mailbox and is always accepted.
- R5: Each accepted message (`msg_valid` and `msg_ready` at a clock edge) produces, in the next cycle, exactly one single-cycle pulse. That pulse is `mbox_send` or `xfer_notice`. `span_off`/`span_len` are valid with `xfer_notice`, and `span_len` equals the message length.
- R6: When no span is outstanding, a new span starts at offset 0.
- R7: Spans are placed back to back from the head without waiting for acknowledgements. Each span lies entirely inside the region (offset plus length at most `REGION`).
- R8: If the space from the head to the region end is too short but the space from offset 0 to the tail is long enough, the span is placed at offset 0, skipping the end.
- R9: A DMA-bound message that fits nowhere, or arrives while `MAX_OUT` spans are outstanding, is held. In that state `msg_ready` is 0, `wait_space` is 1 and no pulse is produced.
- R10: `ack_cnt` = k releases the k oldest outstanding spans in that cycle. A count above the number outstanding releases all of them.
- R11: The placement decision in a cycle uses the ownership before that cycle's acknowledgement. A release takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_start | input | 1 | Request to send the allocation notice |
| alloc_ack | input | 1 | Allocation acknowledge from the receiver |
| alloc_notice | output | 1 | Allocation notice pulse |
| msg_valid | input | 1 | A message is offered |
| msg_len | input | LEN_W | Message length in fragments |
| msg_ready | output | 1 | Offered message is accepted this cycle |
| wait_space | output | 1 | DMA message held for lack of owned space |
| ack_cnt | input | CNT_W | Number of transfers acknowledged this cycle (0 = none) |
| mbox_send | output | 1 | Message goes by mailbox (pulse) |
| xfer_notice | output | 1 | Transfer notice: span handed to receiver (pulse) |
| span_off | output | PTR_W | Offset of the handed span |
| span_len | output | LEN_W | Length of the handed span |

## Verification
The hardest state to reach is a region in which the head has run past the tail, too little space remains at the end, and the space below the tail decides between wrapping and stalling. It also matters that all tracking slots can fill while the pointers coincide. The stimulus reaches this by issuing several spans with no acknowledgement until the head nears the end, then releasing exactly one old span. This opens a gap at the bottom of the region sized to accept one length and reject a slightly longer one. A batched acknowledge arriving in the same cycle as a blocked message then shows that the release only helps from the next cycle.

// File: rtl/dmaspan_pkg.sv
package dmaspan_pkg;
    typedef enum logic [1:0] {
        LINK_OFF      = 2'd0,
        LINK_NOTIFIED = 2'd1,
        LINK_ON       = 2'd2
    } link_e;
endpackage

// File: rtl/dmaspan_fit.sv
// Places a span of len units in the circular region, or reports no fit.
module dmaspan_fit #(
    parameter int REGION = 32,
    parameter int PTR_W  = 5,
    parameter int LEN_W  = 8
) (
    input  logic             empty,
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    input  logic [LEN_W-1:0] len,
    output logic             fits,
    output logic [PTR_W-1:0] off,
    output logic [PTR_W-1:0] new_head
);
    localparam int SUM_W = ((LEN_W > PTR_W) ? LEN_W : PTR_W) + 2;

    logic [SUM_W-1:0] len_w, head_w, tail_w, end_room, end_w;

    always_comb begin
        len_w    = SUM_W'(len);
        head_w   = SUM_W'(head);
        tail_w   = SUM_W'(tail);
        end_room = SUM_W'(REGION) - head_w;
        fits     = 1'b0;
        off      = '0;
        if (empty) begin
            fits = (len_w <= SUM_W'(REGION));
        end else if (head_w > tail_w) begin
            if (len_w <= end_room) begin
                fits = 1'b1;
                off  = head;
            end else if (len_w <= tail_w) begin
                fits = 1'b1;
            end
        end else if (head_w < tail_w) begin
            if (len_w <= (tail_w - head_w)) begin
                fits = 1'b1;
                off  = head;
            end
        end
        end_w = SUM_W'(off) + len_w;
        if (end_w >= SUM_W'(REGION)) begin
            new_head = '0;
        end else begin
            new_head = end_w[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/dmaspan_ring.sv
// Remembers the end pointer of each outstanding span, oldest first.
module dmaspan_ring #(
    parameter int PTR_W   = 5,
    parameter int MAX_OUT = 4,
    parameter int CNT_W   = 3,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PTR_W-1:0] push_end,
    input  logic [CNT_W-1:0] pop_req,
    output logic [CNT_W-1:0] count,
    output logic             rel_valid,
    output logic [PTR_W-1:0] rel_end
);
    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t            s_d, s_q;
    logic [PTR_W-1:0] ends_q [MAX_OUT];
    logic [CNT_W-1:0] pop_n;
    logic [IDX_W-1:0] wr_idx, last_idx;

    always_comb begin
        pop_n     = (pop_req > s_q.cnt) ? s_q.cnt : pop_req;
        rel_valid = (pop_n != '0);
        last_idx  = s_q.rd + IDX_W'(pop_n - CNT_W'(1));
        rel_end   = ends_q[last_idx];
        wr_idx    = s_q.rd + IDX_W'(s_q.cnt);
        s_d       = s_q;
        s_d.rd    = s_q.rd + IDX_W'(pop_n);
        s_d.cnt   = s_q.cnt - pop_n + CNT_W'(push);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ends_q[g] <= '0;
            end else if (push && wr_idx == IDX_W'(g)) begin
                ends_q[g] <= push_end;
            end
        end
    end

    assign count = s_q.cnt;
endmodule

// File: rtl/dmaspan_tracker.sv
module dmaspan_tracker #(
    parameter int REGION     = 32,
    parameter int LEN_W      = 8,
    parameter int MAX_OUT    = 4,
    parameter int MBOX_FRAGS = 3,
    localparam int PTR_W     = $clog2(REGION),
    localparam int CNT_W     = $clog2(MAX_OUT + 1),
    localparam int IDX_W     = $clog2(MAX_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_start,
    input  logic             alloc_ack,
    output logic             alloc_notice,
    input  logic             msg_valid,
    input  logic [LEN_W-1:0] msg_len,
    output logic             msg_ready,
    output logic             wait_space,
    input  logic [CNT_W-1:0] ack_cnt,
    output logic             mbox_send,
    output logic             xfer_notice,
    output logic [PTR_W-1:0] span_off,
    output logic [LEN_W-1:0] span_len
);
    import dmaspan_pkg::*;

    typedef struct packed {
        link_e            link;
        logic             notice;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic             mbox;
        logic             xfer;
        logic [PTR_W-1:0] off;
        logic [LEN_W-1:0] len;
    } state_t;

    state_t           s_d, s_q;
    logic [CNT_W-1:0] out_cnt;
    logic             rel_valid;
    logic [PTR_W-1:0] rel_end;
    logic             fits, empty, slots_full, dma_on, eligible, take, push;
    logic [PTR_W-1:0] fit_off, fit_head;

    assign empty      = (out_cnt == '0);
    assign slots_full = (out_cnt == CNT_W'(MAX_OUT));
    assign dma_on     = (s_q.link == LINK_ON);
    assign eligible   = dma_on && (msg_len > LEN_W'(MBOX_FRAGS));
    assign wait_space = msg_valid && eligible && (!fits || slots_full);
    assign msg_ready  = !wait_space;
    assign take       = msg_valid && msg_ready;
    assign push       = take && eligible;

    dmaspan_fit #(.REGION(REGION), .PTR_W(PTR_W), .LEN_W(LEN_W)) i_fit (
        .empty    (empty),
        .head     (s_q.head),
        .tail     (s_q.tail),
        .len      (msg_len),
        .fits     (fits),
        .off      (fit_off),
        .new_head (fit_head)
    );

    dmaspan_ring #(.PTR_W(PTR_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_end  (fit_head),
        .pop_req   (ack_cnt),
        .count     (out_cnt),
        .rel_valid (rel_valid),
        .rel_end   (rel_end)
    );

    always_comb begin
        s_d        = s_q;
        s_d.notice = 1'b0;
        case (s_q.link)
            LINK_OFF: begin
                if (alloc_start) begin
                    s_d.link   = LINK_NOTIFIED;
                    s_d.notice = 1'b1;
                end
            end
            LINK_NOTIFIED: begin
                if (alloc_ack) begin
                    s_d.link = LINK_ON;
                end
            end
            default: s_d.link = s_q.link;
        endcase

        s_d.mbox = take && !eligible;
        s_d.xfer = push;
        s_d.off  = push ? fit_off : '0;
        s_d.len  = push ? msg_len : '0;

        if (push) begin
            s_d.head = fit_head;
        end
        if (push && empty) begin
            s_d.tail = '0;
        end else if (rel_valid) begin
            s_d.tail = rel_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{link: LINK_OFF, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_notice = s_q.notice;
    assign mbox_send    = s_q.mbox;
    assign xfer_notice  = s_q.xfer;
    assign span_off     = s_q.off;
    assign span_len     = s_q.len;
endmodule

// File: rtl/dmaspan_tracker_chk.sv
module dmaspan_tracker_chk #(
    parameter int REGION     = 32,
    parameter int LEN_W      = 8,
    parameter int MBOX_FRAGS = 3,
    parameter int PTR_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_notice,
    input logic             msg_valid,
    input logic [LEN_W-1:0] msg_len,
    input logic             msg_ready,
    input logic             wait_space,
    input logic             mbox_send,
    input logic             xfer_notice,
    input logic [PTR_W-1:0] span_off,
    input logic [LEN_W-1:0] span_len,
    input logic             dma_on
);
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mbox_send && xfer_notice)); // R5
    AST_NOTICE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> !(mbox_send || xfer_notice)); // R9
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wait_space |-> !msg_ready); // R9
    AST_SPAN_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_notice |-> ((32'(span_off) + 32'(span_len)) <= 32'(REGION))); // R7
    AST_SHORT_MAILBOX: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_len <= LEN_W'(MBOX_FRAGS)) |-> msg_ready); // R4
    AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_len <= LEN_W'(MBOX_FRAGS)) |=> mbox_send); // R4
    AST_CLOSED_MAILBOX: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !dma_on) |=> (mbox_send && !xfer_notice)); // R3
    AST_ALLOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_notice |=> !alloc_notice); // R2
endmodule

bind dmaspan_tracker dmaspan_tracker_chk #(
    .REGION(REGION), .LEN_W(LEN_W), .MBOX_FRAGS(MBOX_FRAGS), .PTR_W(PTR_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_notice (alloc_notice),
    .msg_valid    (msg_valid),
    .msg_len      (msg_len),
    .msg_ready    (msg_ready),
    .wait_space   (wait_space),
    .mbox_send    (mbox_send),
    .xfer_notice  (xfer_notice),
    .span_off     (span_off),
    .span_len     (span_len),
    .dma_on       (dma_on)
);

// File: tb/test_dmaspan_tracker.sv
module test_dmaspan_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_start = 1'b0, alloc_ack = 1'b0;
    logic       alloc_notice;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_len = '0;
    logic       msg_ready, wait_space;
    logic [2:0] ack_cnt = '0;
    logic       mbox_send, xfer_notice;
    logic [4:0] span_off;
    logic [7:0] span_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dmaspan_tracker i_dmaspan_tracker (
        .clk(clk), .rst_n(rst_n), .alloc_start(alloc_start), .alloc_ack(alloc_ack),
        .alloc_notice(alloc_notice), .msg_valid(msg_valid), .msg_len(msg_len),
        .msg_ready(msg_ready), .wait_space(wait_space), .ack_cnt(ack_cnt),
        .mbox_send(mbox_send), .xfer_notice(xfer_notice),
        .span_off(span_off), .span_len(span_len)
    );

    typedef struct packed {
        logic [2:0] ack;
        logic       vld;
        logic [7:0] len;
        logic       rdy;
        logic       dma;
        logic [4:0] off;
    } vec_t;

    // Region 32 units, 4 slots, DMA open. Pointer notes: head/tail after row.
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b1, 8'd8,  1'b1, 1'b1, 5'd0 },  // R6 empty -> 0, head 8
        '{3'd0, 1'b1, 8'd2,  1'b1, 1'b0, 5'd0 },  // R4 short -> mailbox
        '{3'd0, 1'b1, 8'd10, 1'b1, 1'b1, 5'd8 },  // R7 back to back, head 18
        '{3'd0, 1'b1, 8'd12, 1'b1, 1'b1, 5'd18},  // R7 head 30
        '{3'd0, 1'b1, 8'd4,  1'b0, 1'b1, 5'd0 },  // R9 end 2, bottom 0 -> hold
        '{3'd1, 1'b0, 8'd0,  1'b1, 1'b0, 5'd0 },  // R10 release first, tail 8
        '{3'd0, 1'b1, 8'd4,  1'b1, 1'b1, 5'd0 },  // R8 wrap to 0, head 4
        '{3'd0, 1'b1, 8'd5,  1'b0, 1'b1, 5'd0 },  // R9 gap 4 < 5
        '{3'd0, 1'b1, 8'd4,  1'b1, 1'b1, 5'd4 },  // R7 gap exactly 4, 4 slots used
        '{3'd0, 1'b1, 8'd3,  1'b1, 1'b0, 5'd0 },  // R4 short still passes when full
        '{3'd0, 1'b1, 8'd4,  1'b0, 1'b1, 5'd0 },  // R9 slots full
        '{3'd4, 1'b0, 8'd0,  1'b1, 1'b0, 5'd0 },  // R10 batch release of 4
        '{3'd0, 1'b1, 8'd32, 1'b1, 1'b1, 5'd0 },  // R6 whole region
        '{3'd1, 1'b1, 8'd4,  1'b0, 1'b1, 5'd0 },  // R11 same-cycle ack does not help
        '{3'd0, 1'b1, 8'd4,  1'b1, 1'b1, 5'd0 },  // R11 release visible now
        '{3'd3, 1'b0, 8'd0,  1'b1, 1'b0, 5'd0 },  // R10 excess count releases all
        '{3'd0, 1'b1, 8'd32, 1'b1, 1'b1, 5'd0 },  // R10 region fully free again
        '{3'd0, 1'b1, 8'd16, 1'b0, 1'b1, 5'd0 }   // R9 region full
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, check combinational ready, then registered pulses one cycle later.
    task automatic step(input logic [2:0] ack, input logic vld, input logic [7:0] len,
                        input logic rdy, input logic dma, input logic [4:0] off, input string tag);
        ack_cnt = ack; msg_valid = vld; msg_len = len;
        #1;
        check({tag, " R9 msg_ready"}, int'(msg_ready), int'(rdy));
        check({tag, " R9 wait_space"}, int'(wait_space), int'(vld && !rdy));
        @(negedge clk);
        ack_cnt = '0; msg_valid = 1'b0; msg_len = '0;
        check({tag, " R5 mbox_send"}, int'(mbox_send), int'(vld && rdy && !dma));
        check({tag, " R5 xfer_notice"}, int'(xfer_notice), int'(vld && rdy && dma));
        if (vld && rdy && dma) begin
            check({tag, " R7 R8 span_off"}, int'(span_off), int'(off));
            check({tag, " R5 span_len"}, int'(span_len), int'(len));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 alloc_notice", int'(alloc_notice), 0);
        check("R1 mbox_send", int'(mbox_send), 0);
        check("R1 xfer_notice", int'(xfer_notice), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 msg_ready", int'(msg_ready), 1);
        // R3 closed path: long message by mailbox
        step(3'd0, 1'b1, 8'd8, 1'b1, 1'b0, 5'd0, "R3 closed");
        // R2 stray acknowledge is ignored
        alloc_ack = 1'b1;
        @(negedge clk);
        alloc_ack = 1'b0;
        check("R2 no notice on stray ack", int'(alloc_notice), 0);
        step(3'd0, 1'b1, 8'd8, 1'b1, 1'b0, 5'd0, "R2 stray ack keeps closed");
        // R2 notice pulse
        alloc_start = 1'b1;
        @(negedge clk);
        alloc_start = 1'b0;
        check("R2 alloc_notice pulse", int'(alloc_notice), 1);
        @(negedge clk);
        check("R2 alloc_notice single", int'(alloc_notice), 0);
        step(3'd0, 1'b1, 8'd9, 1'b1, 1'b0, 5'd0, "R3 notified not open");
        alloc_ack = 1'b1;
        @(negedge clk);
        alloc_ack = 1'b0;
        // table walk with DMA open
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].ack, VEC[i].vld, VEC[i].len, VEC[i].rdy, VEC[i].dma, VEC[i].off,
                 $sformatf("row %0d", i));
        end
        // R2 start request after open gives no notice
        alloc_start = 1'b1;
        @(negedge clk);
        alloc_start = 1'b0;
        check("R2 no notice once open", int'(alloc_notice), 0);
        // R4 boundary: 4 fragments go by DMA, region holds one 32 span so free it first
        step(3'd1, 1'b0, 8'd0, 1'b1, 1'b0, 5'd0, "R10 free");
        step(3'd0, 1'b1, 8'd4, 1'b1, 1'b1, 5'd0, "R4 len 4 dma");
        step(3'd0, 1'b1, 8'd3, 1'b1, 1'b0, 5'd0, "R4 len 3 mailbox");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule